// File: doc/BRIEF.md
# Base-Register Effective Address Resolver

This block turns 16-bit operand address fields into 16-bit effective addresses. A field is either absolute or based, and its top bit decides which. An absolute field passes through unchanged. A based field names one of eight 16-bit base registers in three of its bits, carries a 12-bit displacement in its low bits, and resolves to that base plus the displacement. Up to two fields are resolved together for two-address instructions. Each field has its own mode bit and is handled independently of the other.

The base registers are also visible in the byte-addressed memory map, in a fixed 16-byte window at 0x00F0. Register N occupies bytes 0x00F0+2N and 0x00F1+2N, with its most significant byte at the lower address. The block snoops byte writes going to memory, and any write that lands in the window updates the matching half of the matching register. A separate load port writes a whole register in one cycle. After reset, register N holds N*0x1000, so every based field starts as an identity segment address.

A request is accepted on a clock edge where the valid strobe is high. The resolved addresses and a response strobe appear after that edge. Register writes made on the same edge take effect only for later requests.

Top module: `ea_resolver`

## Requirements
- R1: When bit 15 of a field is 0, the effective address equals the field value exactly, whatever the base registers hold.
- R2: When bit 15 of a field is 1, bits 14..12 select base register N and the effective address is register N plus the zero-extended displacement in bits 11..0.
- R3: The based sum wraps modulo 65536. For example, base 0xFFF0 plus displacement 0x020 gives 0x0010.
- R4: After reset, base register N holds N shifted left by 12 (0x0000, 0x1000, ... 0x7000).
- R5: A snooped byte write to address 0x00F0+2N replaces bits 15..8 of register N. A write to 0x00F1+2N replaces bits 7..0. The other half is kept.
- R6: A snooped byte write to any address outside 0x00F0..0x00FF leaves every base register unchanged. This includes addresses that share the low byte, such as 0x01F0.
- R7: A load-port write replaces all 16 bits of the selected register.
- R8: A request on the same edge as a register write resolves with the register value from before that write. The next request sees the new value.
- R9: The two fields of one request are resolved independently, each with its own mode bit and register selection.
- R10: The response strobe is high exactly in the cycle after a request edge. On cycles without a request, both address outputs hold their previous values.
- R11: When the load port and a snooped write target the same register on the same edge, the load port value is stored and the snooped byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Resolve the two fields on this edge |
| fld_a | input | 16 | First operand address field |
| fld_b | input | 16 | Second operand address field |
| snp_we | input | 1 | A byte write to memory is happening |
| snp_addr | input | 16 | Byte address of the snooped write |
| snp_data | input | 8 | Byte value of the snooped write |
| ld_we | input | 1 | Whole-register load strobe |
| ld_idx | input | 3 | Register number for the load |
| ld_val | input | 16 | Value to load |
| rsp_valid | output | 1 | Resolved addresses updated on the last edge |
| ea_a | output | 16 | Effective address of the first field |
| ea_b | output | 16 | Effective address of the second field |

## Verification
Both effective addresses and the response strobe are registered, so each result appears exactly one clock edge after the request edge that carried its fields. A register write made on an edge shows up only in the results of requests on later edges. The bench drives every input on the falling edge and computes the expected addresses from its own register model as it stood before that rising edge. Only then does it apply the same edge's writes to the model. It compares the outputs at the following falling edge, so each check reads the result exactly one edge after its request. Hidden register contents are observed by resolving a based field with displacement zero.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int ADDR_W   = 16;
    localparam int NUM_REGS = 8;
    localparam int SEL_W    = $clog2(NUM_REGS);
    localparam int DISP_W   = ADDR_W - 1 - SEL_W;
    localparam int BYTE_W   = 8;
    localparam logic [ADDR_W-1:0] WIN_BASE = 16'h00F0;
    localparam int WIN_BYTES = NUM_REGS * 2;

    typedef logic [ADDR_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  sel_t;
    typedef word_t [NUM_REGS-1:0] bank_t;

    typedef enum logic {
        MODE_ABS   = 1'b0,
        MODE_BASED = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e                   mode;
        sel_t                    sel;
        logic [DISP_W-1:0]       disp;
    } field_t;

    function automatic field_t split_field(word_t f);
        return field_t'(f);
    endfunction

    function automatic word_t reset_base(int n);
        return word_t'(n) << DISP_W;
    endfunction

    function automatic logic in_window(word_t a);
        return (a >= WIN_BASE) && (a < WIN_BASE + word_t'(WIN_BYTES));
    endfunction

    function automatic sel_t window_reg(word_t a);
        word_t off;
        off = a - WIN_BASE;
        return off[SEL_W:1];
    endfunction

endpackage

// File: rtl/ea_bank.sv
module ea_bank
    import ea_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_we,
    input  word_t             snp_addr,
    input  logic [BYTE_W-1:0] snp_data,
    input  logic              ld_we,
    input  sel_t              ld_idx,
    input  word_t             ld_val,
    output bank_t             regs
);

    logic snp_hit;
    sel_t snp_reg;
    logic snp_low;

    always_comb begin
        snp_hit = snp_we && in_window(snp_addr);
        snp_reg = window_reg(snp_addr);
        snp_low = snp_addr[0];
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic ld_here;
        logic snp_here;

        always_comb begin
            ld_here  = ld_we && (ld_idx == sel_t'(i));
            snp_here = snp_hit && (snp_reg == sel_t'(i));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= reset_base(i);
            end else if (ld_here) begin
                regs[i] <= ld_val;
            end else if (snp_here) begin
                if (snp_low)
                    regs[i][BYTE_W-1:0] <= snp_data;
                else
                    regs[i][ADDR_W-1:BYTE_W] <= snp_data;
            end
        end

        a_r4_reset_identity: assert property (@(posedge clk)
            $past(rst) && !rst |-> regs[i] == reset_base(i));

        a_r7_load_whole: assert property (@(posedge clk) disable iff (rst)
            ld_we && ld_idx == sel_t'(i) |=> regs[i] == $past(ld_val));

        a_r6_untouched: assert property (@(posedge clk) disable iff (rst)
            !(ld_we && ld_idx == sel_t'(i)) &&
            !(snp_we && snp_addr == WIN_BASE + word_t'(2*i)) &&
            !(snp_we && snp_addr == WIN_BASE + word_t'(2*i+1))
            |=> $stable(regs[i]));

        a_r5_high_half: assert property (@(posedge clk) disable iff (rst)
            !(ld_we && ld_idx == sel_t'(i)) && snp_we &&
            snp_addr == WIN_BASE + word_t'(2*i)
            |=> regs[i][ADDR_W-1:BYTE_W] == $past(snp_data) &&
                regs[i][BYTE_W-1:0] == $past(regs[i][BYTE_W-1:0]));
    end

endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    input  word_t fld,
    input  bank_t regs,
    output word_t ea
);

    field_t f;
    word_t  ea_next;

    always_comb begin
        f = split_field(fld);
        if (f.mode == MODE_BASED)
            ea_next = regs[f.sel] + word_t'(f.disp);
        else
            ea_next = fld;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ea <= '0;
        else if (req_valid)
            ea <= ea_next;
    end

    a_r1_absolute_pass: assert property (@(posedge clk) disable iff (rst)
        req_valid && !fld[ADDR_W-1] |=> ea == $past(fld));

    a_r2_based_sum: assert property (@(posedge clk) disable iff (rst)
        req_valid && fld[ADDR_W-1]
        |=> ea == $past(regs[fld[ADDR_W-2 -: SEL_W]] + word_t'(fld[DISP_W-1:0])));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(ea));

endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
    import ea_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [15:0] fld_a,
    input  logic [15:0] fld_b,
    input  logic        snp_we,
    input  logic [15:0] snp_addr,
    input  logic [7:0]  snp_data,
    input  logic        ld_we,
    input  logic [2:0]  ld_idx,
    input  logic [15:0] ld_val,
    output logic        rsp_valid,
    output logic [15:0] ea_a,
    output logic [15:0] ea_b
);

    localparam int NUM_PORTS = 2;

    bank_t regs;
    word_t flds [NUM_PORTS];
    word_t eas  [NUM_PORTS];

    always_comb begin
        flds[0] = fld_a;
        flds[1] = fld_b;
        ea_a    = eas[0];
        ea_b    = eas[1];
    end

    ea_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .snp_we   (snp_we),
        .snp_addr (snp_addr),
        .snp_data (snp_data),
        .ld_we    (ld_we),
        .ld_idx   (ld_idx),
        .ld_val   (ld_val),
        .regs     (regs)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        ea_calc u_calc (
            .clk       (clk),
            .rst       (rst),
            .req_valid (req_valid),
            .fld       (flds[p]),
            .regs      (regs),
            .ea        (eas[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            rsp_valid <= 1'b0;
        else
            rsp_valid <= req_valid;
    end

    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r10_rsp_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r11_load_beats_snoop: assert property (@(posedge clk) disable iff (rst)
        ld_we && snp_we && in_window(snp_addr) && window_reg(snp_addr) == ld_idx
        |=> regs[$past(ld_idx)] == $past(ld_val));

endmodule

// File: tb/ea_resolver_bench.sv
module ea_resolver_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] fld_a = '0;
    logic [15:0] fld_b = '0;
    logic        snp_we = 1'b0;
    logic [15:0] snp_addr = '0;
    logic [7:0]  snp_data = '0;
    logic        ld_we = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [15:0] ld_val = '0;
    logic        rsp_valid;
    logic [15:0] ea_a;
    logic [15:0] ea_b;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] model [8];
    logic [15:0] exp_a, exp_b, prev_a, prev_b;
    logic        exp_v;

    always #5 clk = ~clk;

    ea_resolver u_ea_resolver (
        .clk(clk), .rst(rst), .req_valid(req_valid), .fld_a(fld_a), .fld_b(fld_b),
        .snp_we(snp_we), .snp_addr(snp_addr), .snp_data(snp_data),
        .ld_we(ld_we), .ld_idx(ld_idx), .ld_val(ld_val),
        .rsp_valid(rsp_valid), .ea_a(ea_a), .ea_b(ea_b)
    );

    function automatic logic [15:0] resolve(logic [15:0] f);
        if (!f[15]) return f;
        return model[f[14:12]] + {4'h0, f[11:0]};
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) model[i] = 16'(i) << 12;
    endtask

    // Inputs are already set on a falling edge; run one rising edge and check.
    task automatic cycle(string req);
        exp_v = req_valid;
        exp_a = req_valid ? resolve(fld_a) : prev_a;
        exp_b = req_valid ? resolve(fld_b) : prev_b;
        @(posedge clk);
        if (ld_we) model[ld_idx] = ld_val;
        if (snp_we && snp_addr >= 16'h00F0 && snp_addr <= 16'h00FF &&
            !(ld_we && ld_idx == snp_addr[3:1])) begin
            if (snp_addr[0]) model[snp_addr[3:1]][7:0]  = snp_data;
            else             model[snp_addr[3:1]][15:8] = snp_data;
        end
        @(negedge clk);
        chk({req, " rsp_valid"}, {15'h0, rsp_valid}, {15'h0, exp_v});
        chk({req, " ea_a"}, ea_a, exp_a);
        chk({req, " ea_b"}, ea_b, exp_b);
        prev_a = exp_a;
        prev_b = exp_b;
        req_valid = 1'b0; snp_we = 1'b0; ld_we = 1'b0;
    endtask

    task automatic req(logic [15:0] a, logic [15:0] b);
        req_valid = 1'b1; fld_a = a; fld_b = b;
    endtask

    task automatic snoop(logic [15:0] ad, logic [7:0] d);
        snp_we = 1'b1; snp_addr = ad; snp_data = d;
    endtask

    task automatic load(logic [2:0] i, logic [15:0] v);
        ld_we = 1'b1; ld_idx = i; ld_val = v;
    endtask

    initial begin
        #1_000_000;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        prev_a = '0; prev_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: no request, outputs at reset value and strobe low
        cycle("R10 idle after reset");

        // R4: identity bases, read through displacement 0 and 0xFFF
        for (int n = 0; n < 8; n++) begin
            req(16'h8000 | (16'(n) << 12), 16'h8FFF | (16'(n) << 12));
            cycle("R4 reset base");
        end

        // R1: absolute fields pass through
        req(16'h7FFF, 16'h0000);
        cycle("R1 absolute");

        // R7 + R3: load 0xFFF0 into reg 7, then wrap
        load(3'd7, 16'hFFF0);
        cycle("R7 load");
        req(16'hF020, 16'hFFFF);
        cycle("R3 wrap");

        // R1: absolute unaffected after reload of reg 1
        load(3'd1, 16'hABCD);
        cycle("R7 load reg1");
        req(16'h1234, 16'h9000);
        cycle("R1 absolute after reload");

        // R5: high byte at even address, low byte at odd
        snoop(16'h00F4, 8'h5A);
        cycle("R5 snoop high");
        snoop(16'h00F5, 8'hC3);
        cycle("R5 snoop low");
        req(16'hA000, 16'hA001);
        cycle("R5 reg2 readback");

        // R6: out-of-window aliases do not touch registers
        snoop(16'h01F0, 8'hEE); cycle("R6 snoop 0x01F0");
        snoop(16'h00EF, 8'hEE); cycle("R6 snoop 0x00EF");
        snoop(16'h0100, 8'hEE); cycle("R6 snoop 0x0100");
        snoop(16'hF0F6, 8'hEE); cycle("R6 snoop 0xF0F6");
        req(16'h8000, 16'hB000);
        cycle("R6 readback");

        // R8: write and request on the same edge
        load(3'd3, 16'h4444);
        req(16'hB010, 16'h0010);
        cycle("R8 same edge uses old");
        req(16'hB010, 16'h0010);
        cycle("R8 next sees new");
        snoop(16'h00F6, 8'h99);
        req(16'hB000, 16'hB000);
        cycle("R8 snoop same edge");
        req(16'hB000, 16'hB000);
        cycle("R8 snoop next");

        // R11: load and snoop hit the same register
        load(3'd4, 16'h1357);
        snoop(16'h00F8, 8'hFF);
        cycle("R11 collide");
        req(16'hC000, 16'hC000);
        cycle("R11 readback");

        // R9: mixed modes in one request
        req(16'hE123, 16'h0456);
        cycle("R9 mixed");
        req(16'h0456, 16'hD123);
        cycle("R9 mixed swapped");

        // R10: hold with fields changing but no strobe
        fld_a = 16'h1111; fld_b = 16'h9999;
        cycle("R10 hold");

        // Random phase: R2 R5 R6 R7 R8 R9
        for (int k = 0; k < 3000; k++) begin
            req_valid = $urandom_range(0, 3) != 0;
            fld_a = 16'($urandom);
            fld_b = 16'($urandom);
            if ($urandom_range(0, 3) == 0) begin
                snp_we = 1'b1;
                snp_addr = ($urandom_range(0, 3) != 0) ?
                           (16'h00F0 | 16'($urandom_range(0, 15))) : 16'($urandom);
                snp_data = 8'($urandom);
            end
            if ($urandom_range(0, 5) == 0) begin
                ld_we = 1'b1;
                ld_idx = 3'($urandom);
                ld_val = 16'($urandom);
            end
            cycle("R2 random");
        end

        // R4: reset again restores identity
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        prev_a = '0; prev_b = '0;
        req(16'hF000, 16'h9ABC);
        cycle("R4 re-reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule